// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple single-request host port and a four-bank synchronous DRAM. After reset it holds the memory in a power-up wait. It then closes every bank, runs a parameterised number of auto-refresh cycles and programs the mode register. From then on it serves one host access at a time. Each access opens the addressed row, issues a single-beat READ or WRITE after the row-to-column delay and closes the row again. The row is closed either by the column command's auto-precharge flag or by an explicit single-bank PRECHARGE that respects write recovery.

A refresh interval timer raises a pending request once per 64 ms / 4096 at the configured clock rate. A pending refresh wins over any new host request as soon as the current access has finished. Every gap between commands comes from down counters loaded with parameter-derived values, and NOP is driven while any of them is running. Read data is taken from the data bus a fixed number of cycles after the READ and returned on a one-cycle valid strobe.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset release the block drives only NOP for `CLK_KHZ/10` cycles. Its first command is PRECHARGE with A10 = 1 (all banks), followed by `INIT_REFS` AUTO-REFRESH commands and then LOAD MODE. The LOAD MODE address is `CAS_LAT << 4`: burst length 1 in bits 2:0, sequential order in bit 3, latency in bits 6:4, all other bits zero.
- R2: Commands are coded on {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO-REFRESH 0001, LOAD MODE 0000. No other code is driven.
- R3: Each host access issues ACTIVE with the bank on BA and the row on A, then exactly `T_RCD` cycles later READ or WRITE to that bank with the column on the low address bits. A column command never targets a bank without an open row.
- R4: A read's data is sampled from `sd_dq_in` on the `CAS_LAT`-th rising edge after the memory registers the READ. It is returned on `rd_data` with a one-cycle `rd_valid`, and reads complete in request order.
- R5: On WRITE, `sd_dq_oe` is 1 and `sd_dq_out` carries the host data. `sd_dqm` bit i is the inverse of `req_be` bit i, so a lane with byte enable 0 is masked and left unchanged in memory. `sd_dq_oe` is 0 in every other cycle.
- R6: With `req_autopre` = 1, A10 is 1 on the column command and no PRECHARGE follows. With `req_autopre` = 0, a PRECHARGE with A10 = 0 to the same bank follows, at least `T_DPL` cycles after a WRITE. ACTIVE is never issued to a bank whose row is still open.
- R7: After a PRECHARGE, only NOP is driven for `T_RP` cycles. After an auto-precharge column command, only NOP is driven for `T_RP` plus the recovery cycles: `T_DPL` for a write, 1 for a read.
- R8: Consecutive ACTIVE or AUTO-REFRESH commands are at least `T_RC` cycles apart.
- R9: Once initialised, AUTO-REFRESH is issued once per `CLK_KHZ*64/4096` cycles, delayed at most by the access in progress. A pending refresh is served before any new host request.
- R10: `req_ready` is 1 only after initialisation, with no access in progress, all gaps elapsed and no refresh pending. A request is taken in a cycle where both `req_valid` and `req_ready` are 1.
- R11: During reset `sd_cke` is 0, the command is NOP and `req_ready` and `rd_valid` are 0. After reset `sd_cke` is 1 and stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close row with auto precharge |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, 1 = write lane |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | BANK_W | Bank select |
| sd_a | output | ROW_W | Address bus |
| sd_dqm | output | DATA_W/8 | Byte mask, 1 = masked |
| sd_dq_out | output | DATA_W | Data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from memory |

## Verification
The bench builds the block with `CLK_KHZ` = 8192, which gives an 819-cycle power-up wait and a 128-cycle refresh interval. At that rate the whole start-up sequence and several refreshes fit in a short run, and refreshes collide with live traffic. It uses `CAS_LAT` = 3, `T_RCD` = 2, `T_RP` = 3, `T_DPL` = 2 and `T_RC` = 7. With these values the ACTIVE-to-ACTIVE limit, rather than the precharge gap, paces back-to-back reads. Partial byte enables and both closing styles are mixed across all four banks.

// File: rtl/sdc_pkg.sv
// Shared types for the SDRAM command sequencer.
// Assumes a four-signal command word {cs_n, ras_n, cas_n, we_n}.
package sdc_pkg;

    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_BST  = 4'b0110,
        CMD_NOP  = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IREF,
        ST_IMRS,
        ST_IDLE,
        ST_RW,
        ST_PRE
    } seq_state_e;

endpackage

// File: rtl/sdc_gap_counter.sv
// Down counter that enforces a minimum command gap.
// Loading value v keeps idle low for v cycles after the load edge.
// Assumes load_val fits in W bits.
module sdc_gap_counter #(
    parameter int W         = 8,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);

    logic [W-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RESET_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign idle = (cnt_q == '0);

endmodule

// File: rtl/sdc_refresh_timer.sv
// Raises a refresh request every INTERVAL cycles while enabled.
// The request stays up until acknowledged. Assumes INTERVAL > T_RC.
module sdc_refresh_timer #(
    parameter int INTERVAL = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);

    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] tick_q;

    // Interval count and pending flag; a new tick wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            tick_q  <= '0;
            pending <= 1'b0;
        end else if (tick_q == CW'(INTERVAL - 1)) begin
            tick_q  <= '0;
            pending <= 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
            if (ack)
                pending <= 1'b0;
        end
    end

endmodule

// File: rtl/sdc_read_pipe.sv
// Tracks issued READs and samples the data bus after the latency.
// A READ launched at edge E is registered by the memory at E+1.
// Its data is sampled at edge E+1+CAS_LAT.
module sdc_read_pipe #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [CAS_LAT:0] flight_q;

    // Shift the in-flight marks and capture at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flight_q <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            flight_q <= {flight_q[CAS_LAT-1:0], issue};
            rd_valid <= flight_q[CAS_LAT];
            if (flight_q[CAS_LAT])
                rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sdram_seq_ctrl.sv
// SDRAM command sequencer: power-up init, periodic refresh and one
// single-beat access at a time. Each access opens a row and closes it again.
// Assumes COL_W <= 10 so that A10 is free on column commands.
// Assumes every timing parameter is at least 1.
module sdram_seq_ctrl #(
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int CLK_KHZ   = 133000,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_DPL     = 2,
    parameter int CAS_LAT   = 3,
    parameter int INIT_REFS = 8,
    localparam int BE_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [BE_W-1:0]   sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    import sdc_pkg::*;

    localparam int INIT_CYC = CLK_KHZ / 10;
    localparam int REFI     = (CLK_KHZ * 64) / 4096;
    localparam int T_MRD    = 2;
    localparam int GAP_W    = $clog2(INIT_CYC + T_DPL + T_RP + T_RCD + T_MRD + 4);
    localparam int RC_W     = $clog2(T_RC + 1);
    localparam int IREF_W   = $clog2(INIT_REFS + 1);
    localparam logic [GAP_W-1:0] RCD_LOAD   = GAP_W'(T_RCD - 1);
    localparam logic [GAP_W-1:0] RP_LOAD    = GAP_W'(T_RP - 1);
    localparam logic [GAP_W-1:0] DPL_LOAD   = GAP_W'(T_DPL - 1);
    localparam logic [GAP_W-1:0] MRD_LOAD   = GAP_W'(T_MRD - 1);
    localparam logic [GAP_W-1:0] AP_WR_LOAD = GAP_W'(T_DPL + T_RP - 1);
    localparam logic [GAP_W-1:0] AP_RD_LOAD = GAP_W'(T_RP);
    localparam logic [RC_W-1:0]  RC_LOAD    = RC_W'(T_RC - 1);
    localparam logic [ROW_W-1:0] MODE_WORD  = ROW_W'(CAS_LAT << 4);

    seq_state_e state_q, state_d;
    sd_cmd_e    cmd_q, nxt_cmd;

    logic [BANK_W-1:0] nxt_ba;
    logic [ROW_W-1:0]  nxt_a;
    logic [BE_W-1:0]   nxt_dqm;
    logic [DATA_W-1:0] nxt_dq;
    logic              nxt_oe;

    logic              gap_ld, gap_idle, rc_ld, rc_idle;
    logic [GAP_W-1:0]  gap_val;
    logic              ref_pend, ref_ack, accept, rd_issue, iref_inc, init_done;
    logic [IREF_W-1:0] iref_q;

    logic              r_write, r_ap;
    logic [BANK_W-1:0] r_ba;
    logic [COL_W-1:0]  r_col;
    logic [DATA_W-1:0] r_wdata;
    logic [BE_W-1:0]   r_be;

    sdc_gap_counter #(.W(GAP_W), .RESET_VAL(INIT_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_ld), .load_val(gap_val), .idle(gap_idle)
    );

    sdc_gap_counter #(.W(RC_W), .RESET_VAL(0)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(rc_ld), .load_val(RC_LOAD), .idle(rc_idle)
    );

    sdc_refresh_timer #(.INTERVAL(REFI)) u_refi (
        .clk(clk), .rst_n(rst_n), .enable(init_done), .ack(ref_ack), .pending(ref_pend)
    );

    sdc_read_pipe #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_rdp (
        .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign init_done = !(state_q inside {ST_PWRUP, ST_IREF, ST_IMRS});
    assign req_ready = (state_q == ST_IDLE) && gap_idle && rc_idle && !ref_pend;

    // Next-command selection and gap loading per sequencer state.
    always_comb begin
        state_d  = state_q;
        nxt_cmd  = CMD_NOP;
        nxt_ba   = '0;
        nxt_a    = '0;
        nxt_dqm  = '0;
        nxt_dq   = '0;
        nxt_oe   = 1'b0;
        gap_ld   = 1'b0;
        gap_val  = '0;
        rc_ld    = 1'b0;
        ref_ack  = 1'b0;
        accept   = 1'b0;
        rd_issue = 1'b0;
        iref_inc = 1'b0;
        case (state_q)
            ST_PWRUP: if (gap_idle) begin
                nxt_cmd   = CMD_PRE;
                nxt_a[10] = 1'b1;
                gap_ld    = 1'b1;
                gap_val   = RP_LOAD;
                state_d   = ST_IREF;
            end
            ST_IREF: if (gap_idle && rc_idle) begin
                nxt_cmd  = CMD_REF;
                rc_ld    = 1'b1;
                iref_inc = 1'b1;
                if (iref_q == IREF_W'(INIT_REFS - 1))
                    state_d = ST_IMRS;
            end
            ST_IMRS: if (gap_idle && rc_idle) begin
                nxt_cmd = CMD_LMR;
                nxt_a   = MODE_WORD;
                gap_ld  = 1'b1;
                gap_val = MRD_LOAD;
                state_d = ST_IDLE;
            end
            ST_IDLE: if (gap_idle && rc_idle) begin
                if (ref_pend) begin
                    nxt_cmd = CMD_REF;
                    rc_ld   = 1'b1;
                    ref_ack = 1'b1;
                end else if (req_valid) begin
                    accept  = 1'b1;
                    nxt_cmd = CMD_ACT;
                    nxt_ba  = req_bank;
                    nxt_a   = req_row;
                    gap_ld  = 1'b1;
                    gap_val = RCD_LOAD;
                    rc_ld   = 1'b1;
                    state_d = ST_RW;
                end
            end
            ST_RW: if (gap_idle) begin
                nxt_cmd   = r_write ? CMD_WR : CMD_RD;
                nxt_ba    = r_ba;
                nxt_a     = ROW_W'(r_col);
                nxt_a[10] = r_ap;
                gap_ld    = 1'b1;
                if (r_write) begin
                    nxt_dqm = ~r_be;
                    nxt_dq  = r_wdata;
                    nxt_oe  = 1'b1;
                end else begin
                    rd_issue = 1'b1;
                end
                if (r_ap) begin
                    gap_val = r_write ? AP_WR_LOAD : AP_RD_LOAD;
                    state_d = ST_IDLE;
                end else begin
                    gap_val = r_write ? DPL_LOAD : '0;
                    state_d = ST_PRE;
                end
            end
            ST_PRE: if (gap_idle) begin
                nxt_cmd = CMD_PRE;
                nxt_ba  = r_ba;
                gap_ld  = 1'b1;
                gap_val = RP_LOAD;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, pin registers and the latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_PWRUP;
            cmd_q     <= CMD_NOP;
            sd_cke    <= 1'b0;
            sd_ba     <= '0;
            sd_a      <= '0;
            sd_dqm    <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            iref_q    <= '0;
            r_write   <= 1'b0;
            r_ap      <= 1'b0;
            r_ba      <= '0;
            r_col     <= '0;
            r_wdata   <= '0;
            r_be      <= '0;
        end else begin
            state_q   <= state_d;
            cmd_q     <= nxt_cmd;
            sd_cke    <= 1'b1;
            sd_ba     <= nxt_ba;
            sd_a      <= nxt_a;
            sd_dqm    <= nxt_dqm;
            sd_dq_out <= nxt_dq;
            sd_dq_oe  <= nxt_oe;
            if (iref_inc)
                iref_q <= iref_q + 1'b1;
            if (accept) begin
                r_write <= req_write;
                r_ap    <= req_autopre;
                r_ba    <= req_bank;
                r_col   <= req_col;
                r_wdata <= req_wdata;
                r_be    <= req_be;
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdc_checker.sv
// Protocol checker for sdram_seq_ctrl, attached by bind.
// It follows the pin-level command stream and keeps its own bank and gap state.
module sdc_checker #(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 12,
    parameter int T_RP    = 3,
    parameter int T_RC    = 9,
    parameter int CAS_LAT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ROW_W-1:0]  sd_a,
    input logic              sd_dq_oe
);
    localparam int NBANK = 1 << BANK_W;

    logic [3:0]       cw;
    logic             is_rw;
    int unsigned      rp_cnt, rc_cnt;
    logic [NBANK-1:0] open_q;

    assign cw    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_rw = (cw == 4'b0101) || (cw == 4'b0100);

    // Precharge gap window.
    always_ff @(posedge clk) begin
        if (!rst_n)                rp_cnt <= 0;
        else if (cw == 4'b0010)    rp_cnt <= T_RP - 1;
        else if (rp_cnt != 0)      rp_cnt <= rp_cnt - 1;
    end

    // Row cycle window after ACTIVE or AUTO-REFRESH.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rc_cnt <= 0;
        else if (cw == 4'b0011 || cw == 4'b0001)     rc_cnt <= T_RC - 1;
        else if (rc_cnt != 0)                        rc_cnt <= rc_cnt - 1;
    end

    // Open-row tracking per bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= '0;
        else if (cw == 4'b0011)
            open_q[sd_ba] <= 1'b1;
        else if (cw == 4'b0010) begin
            if (sd_a[10]) open_q <= '0;
            else          open_q[sd_ba] <= 1'b0;
        end else if (is_rw && sd_a[10])
            open_q[sd_ba] <= 1'b0;
    end

    // R7
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_cnt != 0) |-> (cw == 4'b0111));
    // R8
    rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_cnt != 0) |-> !(cw == 4'b0011 || cw == 4'b0001));
    // R3
    rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> open_q[sd_ba]);
    // R6
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw == 4'b0011) |-> !open_q[sd_ba]);
    // R5
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cw == 4'b0100));
    // R4
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cw == 4'b0101, CAS_LAT + 1));
    // R11
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sd_cke) |-> sd_cke);
    // R10
    ready_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sd_cke);

endmodule

bind sdram_seq_ctrl sdc_checker #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .T_RP(T_RP), .T_RC(T_RC), .CAS_LAT(CAS_LAT)
) u_sdc_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_seq_ctrl_bench.sv
// Scoreboard bench with a cycle-level memory model and a protocol monitor.
module sdram_seq_ctrl_bench;

    localparam int CLK_KHZ   = 8192;
    localparam int T_RCD     = 2;
    localparam int T_RP      = 3;
    localparam int T_RC      = 7;
    localparam int T_DPL     = 2;
    localparam int CL        = 3;
    localparam int INIT_REFS = 2;
    localparam int INIT_CYC  = CLK_KHZ / 10;
    localparam int REFI      = (CLK_KHZ * 64) / 4096;
    localparam int SLACK     = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0, req_be = '0;
    logic [11:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_a;
    logic [15:0] sd_dq_out, sd_dq_in;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sdram_seq_ctrl #(
        .CLK_KHZ(CLK_KHZ), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
        .T_DPL(T_DPL), .CAS_LAT(CL), .INIT_REFS(INIT_REFS)
    ) u_sdram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model state and the expectation store.
    logic [15:0] dev_mem [int];
    logic [15:0] shadow  [int];
    logic [15:0] exp_q [$];
    logic [15:0] rp_d [0:CL];
    bit          rp_v [0:CL];

    assign sd_dq_in = rp_v[CL] ? rp_d[CL] : 16'h0;

    function automatic int key_of(input logic [1:0] b, input logic [11:0] r,
                                  input logic [8:0] c);
        return int'({b, r, c});
    endfunction

    int  cyc = 0, quiet_until = 0, last_actref = -1000, last_ref = 0, ref_cnt = 0;
    bit  init_done = 0;
    bit  open_b [4];
    int  open_row [4];
    int  last_act [4];
    int  last_wr [4];

    // Memory model and protocol monitor, evaluated mid-cycle.
    always @(negedge clk) begin
        logic [3:0] cw;
        int k;
        if (rst_n) begin
            cyc++;
            for (int i = CL; i > 0; i--) begin
                rp_d[i] = rp_d[i-1];
                rp_v[i] = rp_v[i-1];
            end
            rp_v[0] = 1'b0;
            rp_d[0] = 16'h0;
            cw = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (req_ready && !init_done)
                chk(0, "R10", "ready before init", 1, 0);
            chk(sd_cke == 1'b1, "R11", "cke after reset", sd_cke, 1);
            if (cw != 4'b0100 && sd_dq_oe)
                chk(0, "R5", "oe outside write", 1, 0);
            if (cw != 4'b0111) begin
                chk(cyc >= quiet_until, "R7", "command inside precharge gap", cyc, quiet_until);
                case (cw)
                    4'b0010: begin
                        quiet_until = cyc + T_RP;
                        if (!init_done) begin
                            chk(sd_a[10] == 1'b1, "R1", "init precharge all", sd_a[10], 1);
                            chk(cyc > INIT_CYC, "R1", "power-up wait", cyc, INIT_CYC + 1);
                        end else begin
                            chk(sd_a[10] == 1'b0, "R6", "single-bank precharge", sd_a[10], 0);
                            chk(open_b[sd_ba], "R6", "precharge of open bank", open_b[sd_ba], 1);
                            chk(cyc - last_wr[sd_ba] >= T_DPL, "R6", "write recovery",
                                cyc - last_wr[sd_ba], T_DPL);
                        end
                        if (sd_a[10]) for (int b = 0; b < 4; b++) open_b[b] = 0;
                        else open_b[sd_ba] = 0;
                    end
                    4'b0001: begin
                        chk(cyc - last_actref >= T_RC, "R8", "refresh row cycle",
                            cyc - last_actref, T_RC);
                        last_actref = cyc;
                        if (!init_done) ref_cnt++;
                        else begin
                            chk(cyc - last_ref <= REFI + SLACK, "R9", "refresh interval",
                                cyc - last_ref, REFI);
                            chk(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R9",
                                "refresh with open row", 1, 0);
                        end
                        last_ref = cyc;
                    end
                    4'b0000: begin
                        chk(!init_done && ref_cnt == INIT_REFS, "R1", "init refresh count",
                            ref_cnt, INIT_REFS);
                        chk(sd_a == 12'(CL << 4), "R1", "mode word", sd_a, CL << 4);
                        init_done = 1;
                        last_ref  = cyc;
                    end
                    4'b0011: begin
                        chk(init_done, "R1", "access before init", init_done, 1);
                        chk(!open_b[sd_ba], "R6", "activate on open bank", open_b[sd_ba], 0);
                        chk(cyc - last_actref >= T_RC, "R8", "activate row cycle",
                            cyc - last_actref, T_RC);
                        last_actref      = cyc;
                        open_b[sd_ba]    = 1;
                        open_row[sd_ba]  = int'(sd_a);
                        last_act[sd_ba]  = cyc;
                    end
                    4'b0101, 4'b0100: begin
                        chk(open_b[sd_ba], "R3", "column to closed bank", open_b[sd_ba], 1);
                        chk(cyc - last_act[sd_ba] == T_RCD, "R3", "row-to-column delay",
                            cyc - last_act[sd_ba], T_RCD);
                        k = key_of(sd_ba, 12'(open_row[sd_ba]), sd_a[8:0]);
                        if (cw == 4'b0100) begin
                            chk(sd_dq_oe, "R5", "oe on write", sd_dq_oe, 1);
                            if (!dev_mem.exists(k)) dev_mem[k] = 16'h0;
                            if (!sd_dqm[0]) dev_mem[k][7:0]  = sd_dq_out[7:0];
                            if (!sd_dqm[1]) dev_mem[k][15:8] = sd_dq_out[15:8];
                            last_wr[sd_ba] = cyc;
                        end else begin
                            rp_v[0] = 1'b1;
                            rp_d[0] = dev_mem.exists(k) ? dev_mem[k] : 16'h0;
                        end
                        if (sd_a[10]) begin
                            open_b[sd_ba] = 0;
                            quiet_until = cyc + ((cw == 4'b0100) ? T_DPL : 1) + T_RP;
                        end
                    end
                    default: chk(0, "R2", "unknown command code", cw, 4'b0111);
                endcase
            end
        end
    end

    // Scoreboard monitor: pop and compare each returned read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0)
                chk(0, "R4", "unexpected read data", rd_data, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R4", "read data", rd_data, e);
            end
        end
    end

    // Driver: hand one request over and record what it must return.
    task automatic host_req(input bit w, input logic [1:0] b, input logic [11:0] r,
                            input logic [8:0] c, input logic [15:0] d,
                            input logic [1:0] be, input bit ap);
        int k;
        k = key_of(b, r, c);
        if (w) begin
            if (!shadow.exists(k)) shadow[k] = 16'h0;
            if (be[0]) shadow[k][7:0]  = d[7:0];
            if (be[1]) shadow[k][15:8] = d[15:8];
        end else begin
            exp_q.push_back(shadow.exists(k) ? shadow[k] : 16'h0);
        end
        req_valid = 1; req_write = w; req_bank = b; req_row = r; req_col = c;
        req_wdata = d; req_be = be; req_autopre = ap;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i <= CL; i++) begin rp_v[i] = 0; rp_d[i] = 0; end
        for (int b = 0; b < 4; b++) begin
            open_b[b] = 0; open_row[b] = 0; last_act[b] = 0; last_wr[b] = -100;
        end
        // R11: reset values
        repeat (4) @(negedge clk);
        chk(sd_cke == 1'b0, "R11", "cke in reset", sd_cke, 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R11", "nop in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(!req_ready && !rd_valid, "R11", "ready/valid in reset", {req_ready, rd_valid}, 0);
        #1 rst_n = 1;

        // R5 R6: writes across all banks, both closing styles
        host_req(1, 2'd0, 12'h001, 9'h010, 16'hA1B2, 2'b11, 0);
        host_req(1, 2'd1, 12'h7FF, 9'h1FF, 16'hC3D4, 2'b11, 1);
        host_req(1, 2'd2, 12'hFFF, 9'h000, 16'h1234, 2'b11, 0);
        host_req(1, 2'd3, 12'h800, 9'h0AA, 16'h5678, 2'b11, 1);
        // R5: byte masking
        host_req(1, 2'd0, 12'h001, 9'h010, 16'hEEFF, 2'b01, 1);
        host_req(1, 2'd2, 12'hFFF, 9'h000, 16'h99AA, 2'b10, 0);
        // R4 R3: reads with and without auto precharge
        host_req(0, 2'd0, 12'h001, 9'h010, 16'h0, 2'b11, 0);
        host_req(0, 2'd1, 12'h7FF, 9'h1FF, 16'h0, 2'b11, 1);
        host_req(0, 2'd2, 12'hFFF, 9'h000, 16'h0, 2'b11, 1);
        host_req(0, 2'd3, 12'h800, 9'h0AA, 16'h0, 2'b11, 0);
        // R8: back-to-back reads on one bank
        for (int i = 0; i < 4; i++)
            host_req(0, 2'd1, 12'h7FF, 9'h1FF, 16'h0, 2'b11, i[0]);
        // R9: idle across several refresh intervals, then traffic while refreshing
        repeat (3 * REFI) @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            host_req(1, 2'(i), 12'(i * 37), 9'(i * 5), 16'(i * 16'h0101 + 16'h55), 2'b11, i[1]);
            host_req(0, 2'(i), 12'(i * 37), 9'(i * 5), 16'h0, 2'b11, i[0]);
        end
        host_req(0, 2'd0, 12'h001, 9'h010, 16'h0, 2'b11, 1);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "reads outstanding at end", exp_q.size(), 0);
        chk(cyc - last_ref <= REFI + SLACK, "R9", "refresh kept up", cyc - last_ref, REFI);
        finish_run();
    end

endmodule